// File: doc/BRIEF.md
# Dual Leaky Bucket Cell Rate Shaper

This block decides, for one connection at a time, whether a cell may be transmitted now under the Generic Cell Rate Algorithm (GCRA). It also reports the earliest time at which that connection becomes eligible. Every connection has a context that holds a 3-bit shaping mode, a first increment/limit pair, a first theoretical arrival time (TAT), an 8-bit index into a shared bucket table, and a second TAT. The shared table has 256 entries. Each entry supplies the increment and limit of a connection's second bucket, so many connections can share one rate setting.

A scheduler sends a connection number on a valid/ready request channel. After two cycles it receives the verdict on a valid/ready response channel. If it then transmits a cell for that connection, it pulses a send-commit input, and the block advances the TATs. Contexts and bucket entries are loaded through plain write strobes. Writing a context also restarts its history by setting both TATs to the current time.

Back-pressure rules: only one request is outstanding at a time. `req_ready` is high only when no request is in flight. A response, once raised, stays valid with constant contents until `rsp_ready` is seen high on a clock edge.

Top module: `gcra_shaper`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0. Every context has mode 3'b000, so a connection that has never been written is reported ineligible with earliest time 0.
- R2: A request is taken on an edge where `req_valid` and `req_ready` are both 1. `rsp_valid` is 0 on the next cycle and 1 on the cycle after that, with `rsp_conn` equal to the requested connection. The response holds stable until an edge with `rsp_ready`=1. `req_ready` is 0 while a request or response is outstanding.
- R3: For mode 3'b100 (single bucket), the earliest time is TAT1 − L1. The connection is eligible when that value is not later than `now_i` at the evaluation edge. The bucket-table pair is not used.
- R4: For mode 3'b101 (dual bucket), the connection is eligible only when both TATk − Lk values are not later than `now_i`. The earliest time is the later of the two.
- R5: In dual mode, I2 and L2 are read from the entry of the 256-entry bucket table selected by the context's 8-bit index. Rewriting that entry changes later results for every context that points to it.
- R6: Pair 1 and pair 2 are handled identically. Swapping the contents of the two pairs gives the same verdict and earliest time.
- R7: Every mode other than 3'b100 and 3'b101 is unshaped and is reported as ineligible with earliest time 0.
- R8: A context write stores mode, I1, L1 and index, and sets TAT1 and TAT2 to the current `now_i`.
- R9: A `send_commit` pulse takes effect only when `send_conn` equals the connection of the latest response and that response was eligible. It then sets TATk to max(TATk, `now_i`) + Ik for bucket 1, and also for bucket 2 in dual mode. It takes effect at most once per response. Any other pulse leaves the context unchanged.
- R10: All time comparisons use the sign of the modular difference, so results stay correct when time or TAT values wrap past zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| now_i | input | TW | Current time |
| ctx_we | input | 1 | Context write strobe |
| ctx_waddr | input | CONN_W | Context to write |
| ctx_wmode | input | 3 | Shaping mode code |
| ctx_wi | input | TW | Increment of pair 1 |
| ctx_wl | input | TW | Limit of pair 1 |
| ctx_widx | input | IDX_W | Bucket table index for pair 2 |
| bkt_we | input | 1 | Bucket table write strobe |
| bkt_waddr | input | IDX_W | Bucket entry to write |
| bkt_wi | input | TW | Increment of the entry |
| bkt_wl | input | TW | Limit of the entry |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high |
| req_conn | input | CONN_W | Connection to evaluate |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed when high |
| rsp_conn | output | CONN_W | Connection evaluated |
| rsp_eligible | output | 1 | Cell may be sent now |
| rsp_earliest | output | TW | Earliest eligible time |
| send_commit | input | 1 | A cell was sent |
| send_conn | input | CONN_W | Connection that sent |

## Verification
The assertions take three things for granted about the inputs. First, while a request is in flight, neither a context write nor a commit targets the connection being evaluated. Second, `now_i` never moves backwards between acceptance of a request and its response. Third, all live TAT, limit and time values stay within half the time range of one another, which keeps the modular comparison meaningful. The stimulus meets these conditions by serialising everything. Each evaluation, write and commit finishes before the next one starts, and time values are chosen so that their differences are small even in the wrap cases.

// File: rtl/gcra_pkg.sv
package gcra_pkg;
  localparam logic [2:0] MODE_SINGLE = 3'b100;
  localparam logic [2:0] MODE_DUAL   = 3'b101;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_RESP = 2'd2
  } shp_state_e;
endpackage

// File: rtl/gcra_bucket.sv
module gcra_bucket #(
  parameter int TW = 16
) (
  input  logic [TW-1:0] tat_i,
  input  logic [TW-1:0] lim_i,
  input  logic [TW-1:0] now_i,
  output logic [TW-1:0] start_o,
  output logic          ok_o
);
  logic [TW-1:0] gap;

  always_comb begin
    start_o = tat_i - lim_i;
    gap     = now_i - start_o;
    ok_o    = ~gap[TW-1];
  end
endmodule

// File: rtl/gcra_bkt_table.sv
module gcra_bkt_table #(
  parameter int TW    = 16,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [TW-1:0]    wi,
  input  logic [TW-1:0]    wl,
  input  logic [IDX_W-1:0] la_addr,
  output logic [TW-1:0]    la_lim,
  input  logic [IDX_W-1:0] ib_addr,
  output logic [TW-1:0]    ib_inc
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TW-1:0] inc_mem [DEPTH];
  logic [TW-1:0] lim_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      inc_mem[waddr] <= wi;
      lim_mem[waddr] <= wl;
    end
  end

  assign la_lim = lim_mem[la_addr];
  assign ib_inc = inc_mem[ib_addr];
endmodule

// File: rtl/gcra_ctx_store.sv
module gcra_ctx_store #(
  parameter int CONN_W = 4,
  parameter int TW     = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     now_i,
  input  logic              wr_en,
  input  logic [CONN_W-1:0] wr_addr,
  input  logic [2:0]        wr_mode,
  input  logic [TW-1:0]     wr_i,
  input  logic [TW-1:0]     wr_l,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              up_en,
  input  logic [CONN_W-1:0] up_addr,
  input  logic [TW-1:0]     up_tat1,
  input  logic [TW-1:0]     up_tat2,
  input  logic              rd_en,
  input  logic [CONN_W-1:0] rd_addr,
  output logic [2:0]        q_mode,
  output logic [TW-1:0]     q_l1,
  output logic [IDX_W-1:0]  q_idx,
  output logic [TW-1:0]     q_tat1,
  output logic [TW-1:0]     q_tat2,
  input  logic [CONN_W-1:0] pk_addr,
  output logic [2:0]        pk_mode,
  output logic [TW-1:0]     pk_i1,
  output logic [IDX_W-1:0]  pk_idx,
  output logic [TW-1:0]     pk_tat1,
  output logic [TW-1:0]     pk_tat2
);
  localparam int DEPTH = 1 << CONN_W;

  logic [2:0]       mode_m [DEPTH];
  logic [TW-1:0]    i1_m   [DEPTH];
  logic [TW-1:0]    l1_m   [DEPTH];
  logic [IDX_W-1:0] idx_m  [DEPTH];
  logic [TW-1:0]    tat1_m [DEPTH];
  logic [TW-1:0]    tat2_m [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) begin
        mode_m[k] <= '0;
        i1_m[k]   <= '0;
        l1_m[k]   <= '0;
        idx_m[k]  <= '0;
        tat1_m[k] <= '0;
        tat2_m[k] <= '0;
      end
    end else begin
      if (up_en && !(wr_en && wr_addr == up_addr)) begin
        tat1_m[up_addr] <= up_tat1;
        tat2_m[up_addr] <= up_tat2;
      end
      if (wr_en) begin
        mode_m[wr_addr] <= wr_mode;
        i1_m[wr_addr]   <= wr_i;
        l1_m[wr_addr]   <= wr_l;
        idx_m[wr_addr]  <= wr_idx;
        tat1_m[wr_addr] <= now_i;
        tat2_m[wr_addr] <= now_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_mode <= '0;
      q_l1   <= '0;
      q_idx  <= '0;
      q_tat1 <= '0;
      q_tat2 <= '0;
    end else if (rd_en) begin
      q_mode <= mode_m[rd_addr];
      q_l1   <= l1_m[rd_addr];
      q_idx  <= idx_m[rd_addr];
      q_tat1 <= tat1_m[rd_addr];
      q_tat2 <= tat2_m[rd_addr];
    end
  end

  assign pk_mode = mode_m[pk_addr];
  assign pk_i1   = i1_m[pk_addr];
  assign pk_idx  = idx_m[pk_addr];
  assign pk_tat1 = tat1_m[pk_addr];
  assign pk_tat2 = tat2_m[pk_addr];
endmodule

// File: rtl/gcra_shaper.sv
module gcra_shaper #(
  parameter int CONN_W = 4,
  parameter int TW     = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     now_i,
  input  logic              ctx_we,
  input  logic [CONN_W-1:0] ctx_waddr,
  input  logic [2:0]        ctx_wmode,
  input  logic [TW-1:0]     ctx_wi,
  input  logic [TW-1:0]     ctx_wl,
  input  logic [IDX_W-1:0]  ctx_widx,
  input  logic              bkt_we,
  input  logic [IDX_W-1:0]  bkt_waddr,
  input  logic [TW-1:0]     bkt_wi,
  input  logic [TW-1:0]     bkt_wl,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CONN_W-1:0] req_conn,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [CONN_W-1:0] rsp_conn,
  output logic              rsp_eligible,
  output logic [TW-1:0]     rsp_earliest,
  input  logic              send_commit,
  input  logic [CONN_W-1:0] send_conn
);
  import gcra_pkg::*;

  localparam int NB = 2;

  function automatic logic not_before(input logic [TW-1:0] a, input logic [TW-1:0] b);
    logic [TW-1:0] d;
    d = a - b;
    return ~d[TW-1];
  endfunction

  function automatic logic [TW-1:0] advance(input logic [TW-1:0] tat,
                                            input logic [TW-1:0] now,
                                            input logic [TW-1:0] inc);
    return (not_before(now, tat) ? now : tat) + inc;
  endfunction

  shp_state_e state;
  logic accept;

  logic [2:0]       q_mode;
  logic [TW-1:0]    q_l1, q_tat1, q_tat2, bk_l2;
  logic [IDX_W-1:0] q_idx;
  logic [CONN_W-1:0] cur_conn;

  logic [2:0]       pk_mode;
  logic [TW-1:0]    pk_i1, pk_tat1, pk_tat2, bk_i2;
  logic [IDX_W-1:0] pk_idx;

  logic [TW-1:0] ev_tat   [NB];
  logic [TW-1:0] ev_lim   [NB];
  logic [TW-1:0] ev_start [NB];
  logic          ev_ok    [NB];

  logic shaped, dual, verdict;
  logic [TW-1:0] earliest;

  logic              last_vld, last_elig;
  logic [CONN_W-1:0] last_conn;
  logic              commit_hit, pk_shaped, pk_dual;
  logic [TW-1:0]     new_tat1, new_tat2;

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign accept    = req_valid && req_ready;

  gcra_ctx_store #(.CONN_W(CONN_W), .TW(TW), .IDX_W(IDX_W)) u_ctx (
    .clk(clk), .rst_n(rst_n), .now_i(now_i),
    .wr_en(ctx_we), .wr_addr(ctx_waddr), .wr_mode(ctx_wmode),
    .wr_i(ctx_wi), .wr_l(ctx_wl), .wr_idx(ctx_widx),
    .up_en(commit_hit), .up_addr(send_conn), .up_tat1(new_tat1), .up_tat2(new_tat2),
    .rd_en(accept), .rd_addr(req_conn),
    .q_mode(q_mode), .q_l1(q_l1), .q_idx(q_idx), .q_tat1(q_tat1), .q_tat2(q_tat2),
    .pk_addr(send_conn), .pk_mode(pk_mode), .pk_i1(pk_i1), .pk_idx(pk_idx),
    .pk_tat1(pk_tat1), .pk_tat2(pk_tat2)
  );

  gcra_bkt_table #(.TW(TW), .IDX_W(IDX_W)) u_bkt (
    .clk(clk), .we(bkt_we), .waddr(bkt_waddr), .wi(bkt_wi), .wl(bkt_wl),
    .la_addr(q_idx), .la_lim(bk_l2),
    .ib_addr(pk_idx), .ib_inc(bk_i2)
  );

  assign ev_tat[0] = q_tat1;
  assign ev_lim[0] = q_l1;
  assign ev_tat[1] = q_tat2;
  assign ev_lim[1] = bk_l2;

  for (genvar b = 0; b < NB; b++) begin : g_bkt
    gcra_bucket #(.TW(TW)) u_test (
      .tat_i(ev_tat[b]), .lim_i(ev_lim[b]), .now_i(now_i),
      .start_o(ev_start[b]), .ok_o(ev_ok[b])
    );
  end

  always_comb begin
    shaped  = (q_mode == MODE_SINGLE) || (q_mode == MODE_DUAL);
    dual    = (q_mode == MODE_DUAL);
    verdict = shaped && ev_ok[0] && (!dual || ev_ok[1]);
    if (!shaped)
      earliest = '0;
    else if (!dual || not_before(ev_start[0], ev_start[1]))
      earliest = ev_start[0];
    else
      earliest = ev_start[1];
  end

  always_comb begin
    pk_shaped  = (pk_mode == MODE_SINGLE) || (pk_mode == MODE_DUAL);
    pk_dual    = (pk_mode == MODE_DUAL);
    commit_hit = send_commit && last_vld && last_elig && pk_shaped &&
                 (send_conn == last_conn);
    new_tat1   = advance(pk_tat1, now_i, pk_i1);
    new_tat2   = pk_dual ? advance(pk_tat2, now_i, bk_i2) : pk_tat2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      cur_conn     <= '0;
      rsp_conn     <= '0;
      rsp_eligible <= 1'b0;
      rsp_earliest <= '0;
      last_vld     <= 1'b0;
      last_elig    <= 1'b0;
      last_conn    <= '0;
    end else begin
      if (commit_hit) last_vld <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          cur_conn <= req_conn;
          state    <= ST_LOOK;
        end
        ST_LOOK: begin
          rsp_conn     <= cur_conn;
          rsp_eligible <= verdict;
          rsp_earliest <= earliest;
          last_vld     <= 1'b1;
          last_elig    <= verdict;
          last_conn    <= cur_conn;
          state        <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_earliest) &&
      $stable(rsp_eligible) && $stable(rsp_conn)); // R2

  AST_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !rsp_valid ##1 rsp_valid); // R2

  AST_ELIG_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && rsp_eligible |-> not_before($past(now_i), rsp_earliest)); // R3

  AST_DUAL_LATEST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && $past(q_mode == MODE_DUAL) |->
      not_before(rsp_earliest, $past(ev_start[0])) &&
      not_before(rsp_earliest, $past(ev_start[1]))); // R4

  AST_UNSHAPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && !$past(q_mode == MODE_SINGLE) && !$past(q_mode == MODE_DUAL)
      |-> !rsp_eligible && rsp_earliest == '0); // R7
endmodule

// File: tb/tb_gcra_shaper.sv
module tb_gcra_shaper;
  localparam int CONN_W = 4;
  localparam int TW     = 16;
  localparam int IDX_W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TW-1:0] now_i = '0;
  logic ctx_we = 1'b0;
  logic [CONN_W-1:0] ctx_waddr = '0;
  logic [2:0] ctx_wmode = '0;
  logic [TW-1:0] ctx_wi = '0, ctx_wl = '0;
  logic [IDX_W-1:0] ctx_widx = '0;
  logic bkt_we = 1'b0;
  logic [IDX_W-1:0] bkt_waddr = '0;
  logic [TW-1:0] bkt_wi = '0, bkt_wl = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [CONN_W-1:0] req_conn = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b0;
  logic [CONN_W-1:0] rsp_conn;
  logic rsp_eligible;
  logic [TW-1:0] rsp_earliest;
  logic send_commit = 1'b0;
  logic [CONN_W-1:0] send_conn = '0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gcra_shaper #(.CONN_W(CONN_W), .TW(TW), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n), .now_i(now_i),
    .ctx_we(ctx_we), .ctx_waddr(ctx_waddr), .ctx_wmode(ctx_wmode),
    .ctx_wi(ctx_wi), .ctx_wl(ctx_wl), .ctx_widx(ctx_widx),
    .bkt_we(bkt_we), .bkt_waddr(bkt_waddr), .bkt_wi(bkt_wi), .bkt_wl(bkt_wl),
    .req_valid(req_valid), .req_ready(req_ready), .req_conn(req_conn),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_conn(rsp_conn),
    .rsp_eligible(rsp_eligible), .rsp_earliest(rsp_earliest),
    .send_commit(send_commit), .send_conn(send_conn)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic [15:0] i1;
    logic [15:0] l1;
    logic [7:0]  idx;
    logic [15:0] bi;
    logic [15:0] bl;
    logic [15:0] t_init;
    logic [15:0] t_eval;
    logic        elig;
    logic [15:0] earl;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{3'b100, 16'd10, 16'd4,  8'd7,   16'd0,  16'd0,  16'd100,   16'd96,  1'b1, 16'd96},
    '{3'b100, 16'd10, 16'd4,  8'd7,   16'd0,  16'd0,  16'd100,   16'd95,  1'b0, 16'd96},
    '{3'b101, 16'd10, 16'd2,  8'd200, 16'd40, 16'd20, 16'd200,   16'd198, 1'b1, 16'd198},
    '{3'b101, 16'd10, 16'd2,  8'd200, 16'd40, 16'd20, 16'd200,   16'd197, 1'b0, 16'd198},
    '{3'b101, 16'd10, 16'd30, 8'd255, 16'd40, 16'd5,  16'd200,   16'd190, 1'b0, 16'd195},
    '{3'b101, 16'd40, 16'd5,  8'd0,   16'd10, 16'd30, 16'd200,   16'd195, 1'b1, 16'd195},
    '{3'b000, 16'd10, 16'd4,  8'd7,   16'd0,  16'd0,  16'd100,   16'd500, 1'b0, 16'd0},
    '{3'b111, 16'd10, 16'd4,  8'd7,   16'd0,  16'd0,  16'd100,   16'd500, 1'b0, 16'd0},
    '{3'b110, 16'd10, 16'd4,  8'd7,   16'd0,  16'd0,  16'd100,   16'd500, 1'b0, 16'd0},
    '{3'b100, 16'd10, 16'd10, 8'd7,   16'd0,  16'd0,  16'd5,     16'd3,   1'b1, 16'd65531},
    '{3'b100, 16'd10, 16'd2,  8'd7,   16'd0,  16'd0,  16'd65530, 16'd4,   1'b1, 16'd65528}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_bkt(input logic [7:0] a, input logic [15:0] i, input logic [15:0] l);
    @(negedge clk);
    bkt_we = 1'b1; bkt_waddr = a; bkt_wi = i; bkt_wl = l;
    @(negedge clk);
    bkt_we = 1'b0;
  endtask

  task automatic wr_ctx(input logic [3:0] c, input logic [2:0] m, input logic [15:0] i,
                        input logic [15:0] l, input logic [7:0] x, input logic [15:0] t);
    @(negedge clk);
    now_i = t; ctx_we = 1'b1; ctx_waddr = c; ctx_wmode = m;
    ctx_wi = i; ctx_wl = l; ctx_widx = x;
    @(negedge clk);
    ctx_we = 1'b0;
  endtask

  task automatic run_eval(input logic [3:0] c, input logic [15:0] t,
                          output logic el, output logic [15:0] ea);
    @(negedge clk);
    now_i = t; req_conn = c; req_valid = 1'b1;
    chk("R2 ready before request", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 no response one cycle after accept", {31'd0, rsp_valid}, 32'd0);
    @(negedge clk);
    chk("R2 response two cycles after accept", {31'd0, rsp_valid}, 32'd1);
    chk("R2 response connection", {28'd0, rsp_conn}, {28'd0, c});
    el = rsp_eligible;
    ea = rsp_earliest;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic commit(input logic [3:0] c, input logic [15:0] t);
    @(negedge clk);
    now_i = t; send_commit = 1'b1; send_conn = c;
    @(negedge clk);
    send_commit = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic el;
    logic [15:0] ea;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 req_ready after reset", {31'd0, req_ready}, 32'd1);
    chk("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    run_eval(4'd3, 16'd1000, el, ea);
    chk("R1 unwritten context ineligible", {31'd0, el}, 32'd0);
    chk("R1 unwritten context earliest", {16'd0, ea}, 32'd0);

    // Vector table: R3 single, R4 dual, R5 lookup, R6 symmetry, R7 unshaped, R8 init, R10 wrap
    for (int v = 0; v < NV; v++) begin
      wr_bkt(VECS[v].idx, VECS[v].bi, VECS[v].bl);
      wr_ctx(4'd1, VECS[v].mode, VECS[v].i1, VECS[v].l1, VECS[v].idx, VECS[v].t_init);
      run_eval(4'd1, VECS[v].t_eval, el, ea);
      chk($sformatf("R3/R4/R7/R8/R10 vec %0d eligible", v), {31'd0, el}, {31'd0, VECS[v].elig});
      chk($sformatf("R3/R4/R6/R7/R10 vec %0d earliest", v), {16'd0, ea}, {16'd0, VECS[v].earl});
    end

    // R9: single-bucket commit advances TAT1
    wr_ctx(4'd2, 3'b100, 16'd10, 16'd0, 8'd7, 16'd50);
    run_eval(4'd2, 16'd50, el, ea);
    chk("R9 fresh connection eligible", {31'd0, el}, 32'd1);
    commit(4'd2, 16'd50);
    run_eval(4'd2, 16'd55, el, ea);
    chk("R9 single commit earliest", {16'd0, ea}, 32'd60);
    chk("R9 single commit not eligible early", {31'd0, el}, 32'd0);
    commit(4'd2, 16'd55);
    run_eval(4'd2, 16'd60, el, ea);
    chk("R9 commit after ineligible ignored", {16'd0, ea}, 32'd60);
    commit(4'd5, 16'd60);
    run_eval(4'd2, 16'd60, el, ea);
    chk("R9 commit for other connection ignored", {16'd0, ea}, 32'd60);
    commit(4'd2, 16'd70);
    run_eval(4'd2, 16'd70, el, ea);
    chk("R9 commit uses later of TAT and now", {16'd0, ea}, 32'd80);
    commit(4'd2, 16'd70);
    commit(4'd2, 16'd70);
    run_eval(4'd2, 16'd70, el, ea);
    chk("R9 one commit per response", {16'd0, ea}, 32'd80);

    // R9 dual: both buckets advance; R5 shared entry rewrite
    wr_bkt(8'd9, 16'd25, 16'd15);
    wr_ctx(4'd4, 3'b101, 16'd5, 16'd0, 8'd9, 16'd300);
    run_eval(4'd4, 16'd300, el, ea);
    chk("R4 dual fresh eligible", {31'd0, el}, 32'd1);
    chk("R4 dual fresh earliest", {16'd0, ea}, 32'd300);
    commit(4'd4, 16'd300);
    run_eval(4'd4, 16'd300, el, ea);
    chk("R9 dual commit earliest", {16'd0, ea}, 32'd310);
    wr_bkt(8'd9, 16'd25, 16'd40);
    run_eval(4'd4, 16'd306, el, ea);
    chk("R5 rewritten entry earliest", {16'd0, ea}, 32'd305);
    chk("R5 rewritten entry eligible", {31'd0, el}, 32'd1);

    // R2: back-pressure holds the response
    @(negedge clk);
    now_i = 16'd400; req_conn = 4'd4; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 response held under back-pressure", {31'd0, rsp_valid}, 32'd1);
    chk("R2 no new request while held", {31'd0, req_ready}, 32'd0);
    chk("R2 held earliest", {16'd0, rsp_earliest}, 32'd305);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R2 response released", {31'd0, rsp_valid}, 32'd0);
    chk("R2 ready after release", {31'd0, req_ready}, 32'd1);

    finish_run();
  end
endmodule